// File: doc/BRIEF.md
# Multi-Frame SPI Master Controller

This block is a synchronous serial transfer engine that acts as an SPI master. A host loads up to four 32-bit transmit words, sets the frame length, frame count, bit order and clock mode, and then issues a start command. The engine drives SCK and shifts each frame out on MOSI while it captures MISO. The frames of one transfer follow each other with no gap. The received frames land in a result buffer that the host can read.

The transmit words and the configuration are copied into the engine when a transfer starts. The result buffer is replaced only when the transfer completes. The host can therefore prepare the next transfer and read the previous result while a transfer is running. In four-wire mode an active-low select frames the whole transfer. In three-wire mode the select output is held inactive. Host access uses a valid/ready register port. The port stalls a start command that arrives while a transfer is running.

Top module: `spi_mf_master`

Register map (word addresses on `bus_addr_i`):

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | Configuration word (field layout in R1) |
| 1 | write | Start command: a write with bit 0 set starts a transfer |
| 1 | read | Busy flag in bit 0 |
| 4 to 7 | read/write | Transmit slots 0 to 3 |
| 8 to 11 | read | Receive slots 0 to 3 |
| any other | read | Returns 0 |

## Requirements
- R1: The configuration word holds these fields: length in bits [5:0], frame count minus one in bits [7:6], LSB-first in bit [8], CPOL in bit [9], CPHA in bit [10], three-wire in bit [11] and divider N in bits [23:16]. The other bits read as 0. A write whose length is not 8 to 16, 20, 24 or 32 is ignored as a whole.
- R2: A start sends 1 to 4 frames back to back. SCK makes exactly 2×length×count edges, with no idle half-period between frames.
- R3: In MSB-first order (bit 8 = 0) the bits of a frame go out from bit length−1 down to bit 0. In LSB-first order they go out from bit 0 upward. Received bits are placed in the same order.
- R4: Each frame uses the low-order length bits of its 32-bit slot. A received slot is right-aligned and zero-extended. Receive slots beyond the frame count read as 0 after the transfer.
- R5: Transmit words, slave data and configuration are captured at start. Host writes during a transfer do not affect it. The receive slots keep the previous result until the transfer completes.
- R6: In four-wire mode, cs_n_o goes low on the clock edge that accepts the start. The first SCK edge comes N+1 cycles later. cs_n_o stays low between frames and goes high N+1 cycles after the last SCK edge.
- R7: In three-wire mode, cs_n_o stays high throughout a transfer.
- R8: SCK edges are N+1 system cycles apart. SCK rests at CPOL when idle. With CPHA=0, MISO is sampled on the first edge of each bit and MOSI changes on the second. With CPHA=1, MOSI changes on the first edge and MISO is sampled on the second.
- R9: busy_o is high from the cycle after the start is accepted until the select is released. done_o is high for exactly one cycle, the first cycle with busy_o low. The new receive data can be read from the cycle after done_o.
- R10: While busy_o is high, a start write sees bus_ready_o low and stalls until the transfer ends. All other accesses see bus_ready_o high.
- R11: After reset, cs_n_o=1, sck_o=0, mosi_o=0, busy_o=0 and done_o=0. The configuration reads 0x00010008: 8-bit frames, one frame, MSB-first, mode 0, N=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_ready_o | output | 1 | Access accepted; low only for a start write during a transfer |
| bus_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low slave select |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the host issues at most one bus access per cycle and holds each access stable until it is accepted. They also assume that MISO changes only between sampling edges. The bench meets these assumptions by driving the bus and MISO only on the falling system clock, one access at a time. Its slave model presents each bit as soon as the previous SCK edge has occurred. The per-cycle reference model computes the expected SCK, select, MOSI, busy and done values from the edge count elapsed since the start. It covers all CPOL/CPHA combinations, both bit orders, both wire modes and the boundary lengths 9, 16, 20, 24 and 32.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = 32;
  localparam int DIV_W  = 8;
  localparam int LEN_W  = 6;
  localparam int CNT_W  = $clog2(SLOTS);
  localparam int BUF_W  = SLOTS * SLOT_W;

  typedef logic [SLOTS-1:0][SLOT_W-1:0] buf_t;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             three_wire;
    logic             cpha;
    logic             cpol;
    logic             lsb_first;
    logic [CNT_W-1:0] frames_m1;
    logic [LEN_W-1:0] len;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{div: DIV_W'(1), three_wire: 1'b0, cpha: 1'b0,
                                 cpol: 1'b0, lsb_first: 1'b0,
                                 frames_m1: '0, len: LEN_W'(8)};

  function automatic logic len_ok(logic [LEN_W-1:0] l);
    return (l >= LEN_W'(8) && l <= LEN_W'(16)) || l == LEN_W'(20) ||
           l == LEN_W'(24) || l == LEN_W'(32);
  endfunction
endpackage

// File: rtl/spi_mf_clkgen.sv
module spi_mf_clkgen
  import spi_mf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end

  // R8
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= div_i));
endmodule

// File: rtl/spi_mf_regs.sv
module spi_mf_regs
  import spi_mf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_valid_i,
  input  logic        bus_write_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic        bus_ready_o,
  output logic [31:0] bus_rdata_o,
  input  logic        busy_i,
  input  logic        done_i,
  input  buf_t        rx_work_i,
  output cfg_t        cfg_o,
  output buf_t        tx_o,
  output logic        start_o
);
  localparam logic [3:0] ADDR_CFG = 4'd0;
  localparam logic [3:0] ADDR_CMD = 4'd1;

  cfg_t cfg_q;
  buf_t tx_q, rx_q;
  logic is_cmd, wr;
  logic unused_wdata;

  assign unused_wdata = ^{bus_wdata_i[31:24], bus_wdata_i[15:12]};

  assign is_cmd      = (bus_addr_i == ADDR_CMD);
  assign bus_ready_o = !(bus_write_i && is_cmd && busy_i);
  assign wr          = bus_valid_i && bus_write_i && bus_ready_o;
  assign start_o     = wr && is_cmd && bus_wdata_i[0];
  assign cfg_o       = cfg_q;
  assign tx_o        = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RESET;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      if (wr && bus_addr_i == ADDR_CFG && len_ok(bus_wdata_i[5:0])) begin
        cfg_q.len        <= bus_wdata_i[5:0];
        cfg_q.frames_m1  <= bus_wdata_i[7:6];
        cfg_q.lsb_first  <= bus_wdata_i[8];
        cfg_q.cpol       <= bus_wdata_i[9];
        cfg_q.cpha       <= bus_wdata_i[10];
        cfg_q.three_wire <= bus_wdata_i[11];
        cfg_q.div        <= bus_wdata_i[23:16];
      end
      if (wr && bus_addr_i[3:2] == 2'b01) tx_q[bus_addr_i[1:0]] <= bus_wdata_i;
      if (done_i) rx_q <= rx_work_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_CFG)
      bus_rdata_o = {8'b0, cfg_q.div, 4'b0, cfg_q.three_wire, cfg_q.cpha, cfg_q.cpol,
                     cfg_q.lsb_first, cfg_q.frames_m1, cfg_q.len};
    else if (is_cmd)                 bus_rdata_o = {31'b0, busy_i};
    else if (bus_addr_i[3:2] == 2'b01) bus_rdata_o = tx_q[bus_addr_i[1:0]];
    else if (bus_addr_i[3:2] == 2'b10) bus_rdata_o = rx_q[bus_addr_i[1:0]];
  end

  // R1
  cfg_len_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_ok(cfg_q.len));
endmodule

// File: rtl/spi_mf_engine.sv
module spi_mf_engine
  import spi_mf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  cfg_t             cfg_i,
  input  buf_t             tx_i,
  input  logic             miso_i,
  input  logic             tick_i,
  output logic             en_o,
  output logic [DIV_W-1:0] div_o,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             cs_n_o,
  output logic             busy_o,
  output logic             done_o,
  output buf_t             rx_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TRAIL} state_e;

  state_e           state_q;
  cfg_t             act_q;
  buf_t             tx_q, rx_q;
  logic [5:0]       edge_q;
  logic [CNT_W-1:0] frame_q;
  logic             phase_q, done_q;
  logic [6:0]       edge_last;
  logic             frame_end, last_frame, sample_edge;
  logic [4:0]       bit_num, bit_pos;

  assign edge_last   = {act_q.len, 1'b0} - 7'd1;
  assign frame_end   = ({1'b0, edge_q} == edge_last);
  assign last_frame  = (frame_q == act_q.frames_m1);
  assign sample_edge = act_q.cpha ? edge_q[0] : !edge_q[0];

  always_comb begin
    if (!act_q.cpha)       bit_num = edge_q[5:1];
    else if (edge_q == '0) bit_num = '0;
    else                   bit_num = 5'((edge_q - 6'd1) >> 1);
    bit_pos = act_q.lsb_first ? bit_num : act_q.len[4:0] - 5'd1 - bit_num;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= CFG_RESET;
      tx_q    <= '0;
      rx_q    <= '0;
      edge_q  <= '0;
      frame_q <= '0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          act_q   <= cfg_i;
          tx_q    <= tx_i;
          rx_q    <= '0;
          edge_q  <= '0;
          frame_q <= '0;
          phase_q <= 1'b0;
          state_q <= ST_RUN;
        end
        ST_RUN: if (tick_i) begin
          phase_q <= ~phase_q;
          if (sample_edge) rx_q[frame_q][bit_pos] <= miso_i;
          if (frame_end) begin
            edge_q <= '0;
            if (last_frame) state_q <= ST_TRAIL;
            else            frame_q <= frame_q + CNT_W'(1);
          end else begin
            edge_q <= edge_q + 6'd1;
          end
        end
        ST_TRAIL: if (tick_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign en_o   = (state_q != ST_IDLE);
  assign div_o  = act_q.div;
  assign busy_o = en_o;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign mosi_o = (state_q == ST_RUN) ? tx_q[frame_q][bit_pos] : 1'b0;
  assign sck_o  = ((state_q == ST_IDLE) ? cfg_i.cpol : act_q.cpol) ^ phase_q;
  assign cs_n_o = (state_q == ST_IDLE) || act_q.three_wire;

  // R6
  cs_low_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> busy_o);
  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  // R10
  start_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  // R8
  sck_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !tick_i) |=> $stable(sck_o));
  // R2
  frame_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (frame_q <= act_q.frames_m1));
endmodule

// File: rtl/spi_mf_master.sv
module spi_mf_master
  import spi_mf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_valid_i,
  input  logic        bus_write_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic        bus_ready_o,
  output logic [31:0] bus_rdata_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_n_o,
  output logic        busy_o,
  output logic        done_o
);
  cfg_t             cfg;
  buf_t             tx_buf, rx_work;
  logic             start, tick, en;
  logic [DIV_W-1:0] div;

  spi_mf_regs i_regs (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_addr_i, .bus_wdata_i,
    .bus_ready_o, .bus_rdata_o,
    .busy_i(busy_o), .done_i(done_o), .rx_work_i(rx_work),
    .cfg_o(cfg), .tx_o(tx_buf), .start_o(start)
  );

  spi_mf_clkgen i_clkgen (
    .clk_i, .rst_ni, .en_i(en), .div_i(div), .tick_o(tick)
  );

  spi_mf_engine i_engine (
    .clk_i, .rst_ni, .start_i(start), .cfg_i(cfg), .tx_i(tx_buf), .miso_i,
    .tick_i(tick), .en_o(en), .div_o(div), .sck_o, .mosi_o, .cs_n_o,
    .busy_o, .done_o, .rx_o(rx_work)
  );
endmodule

// File: tb/test_spi_mf_master.sv
module test_spi_mf_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, miso = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, sck, mosi, cs_n, busy, done;
  logic [31:0] bus_rdata;

  int checks = 0, errors = 0, cyc = 0;

  logic [31:0] sh_cfg = 32'h0001_0008;
  logic [31:0] sh_tx[4], slave_w[4], rx_exp[4], m_tx[4];
  bit m_busy = 0, m_done = 0, mlsb, mcpol, mcpha, m3w;
  int m_t = 0, mL = 8, mF = 1, mH = 2;

  spi_mf_master i_spi_mf_master (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_ready_o(bus_ready),
    .bus_rdata_o(bus_rdata), .sck_o(sck), .mosi_o(mosi), .miso_i(miso),
    .cs_n_o(cs_n), .busy_o(busy), .done_o(done)
  );

  initial forever #4 clk = ~clk;

  function automatic bit len_legal(int l);
    return (l >= 8 && l <= 16) || l == 20 || l == 24 || l == 32;
  endfunction

  function automatic int bit_pos(int k);
    int e, bn;
    e  = k % (2 * mL);
    bn = mcpha ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
    return mlsb ? bn : mL - 1 - bn;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // reference model: advances on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      m_done = 0;
      if (m_busy) begin
        m_t++;
        if (m_t == mH * (2 * mL * mF + 1)) begin
          m_busy = 0;
          m_done = 1;
          for (int i = 0; i < 4; i++)
            rx_exp[i] = (i < mF) ? (slave_w[i] & ((mL == 32) ? 32'hFFFF_FFFF
                                                  : ((32'd1 << mL) - 32'd1))) : 32'd0;
        end
      end else if (bus_valid && bus_write && bus_addr == 4'd1 && bus_wdata[0]) begin
        m_busy = 1; m_t = 0;
        mL = int'(sh_cfg[5:0]); mF = int'(sh_cfg[7:6]) + 1; mlsb = sh_cfg[8];
        mcpol = sh_cfg[9]; mcpha = sh_cfg[10]; m3w = sh_cfg[11];
        mH = int'(sh_cfg[23:16]) + 1;
        for (int i = 0; i < 4; i++) m_tx[i] = sh_tx[i];
      end
      if (bus_valid && bus_write) begin
        if (bus_addr == 4'd0 && len_legal(int'(bus_wdata[5:0])))
          sh_cfg = bus_wdata & 32'h00FF_0FFF;
        if (bus_addr[3:2] == 2'b01) sh_tx[bus_addr[1:0]] = bus_wdata;
      end
    end
  end

  // compare every cycle, drive slave data
  always @(negedge clk) begin
    if (rst_n) begin
      int k, E, f;
      logic exp_sck, exp_mosi;
      E = 2 * mL * mF;
      k = m_busy ? m_t / mH : 0;
      if (k > E) k = E;
      f = k / (2 * mL);
      exp_sck  = (m_busy ? mcpol : sh_cfg[9]) ^ k[0];
      exp_mosi = (m_busy && k < E) ? m_tx[f][bit_pos(k)] : 1'b0;
      chk("R9", "busy_o", {31'b0, busy}, {31'b0, m_busy});
      chk("R9", "done_o", {31'b0, done}, {31'b0, m_done});
      chk(m3w ? "R7" : "R6", "cs_n_o", {31'b0, cs_n}, {31'b0, !(m_busy && !m3w)});
      chk("R8", "sck_o", {31'b0, sck}, {31'b0, exp_sck});
      chk("R3", "mosi_o", {31'b0, mosi}, {31'b0, exp_mosi});
      miso = (m_busy && k < E) ? slave_w[f][bit_pos(k)] : 1'b0;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R9 watchdog expired: got busy=%0b expected idle", busy);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
  endtask

  task automatic load(logic [31:0] cfg, logic [31:0] seed);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      slave_w[i] = {seed[7:0] ^ 8'hC3, seed[31:8]} + 32'h0101_0101 * (i + 1);
      wr(4'd4 + 4'(i), seed ^ (32'h9E37_79B9 * (i + 1)));
    end
    wr(4'd0, cfg);
    rd(4'd0, d);
    chk("R1", "cfg readback", d, cfg);
  endtask

  task automatic check_rx(string req);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(4'd8 + 4'(i), d);
      chk(req, "rx slot", d, rx_exp[i]);
    end
  endtask

  task automatic xfer(logic [31:0] cfg, logic [31:0] seed);
    load(cfg, seed);
    wr(4'd1, 32'd1);
    wait_idle();
    check_rx("R4");
  endtask

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin sh_tx[i] = '0; slave_w[i] = '0; rx_exp[i] = '0; m_tx[i] = '0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "cs_n_o", {31'b0, cs_n}, 32'd1);
    chk("R11", "sck_o", {31'b0, sck}, 32'd0);
    chk("R11", "mosi_o", {31'b0, mosi}, 32'd0);
    chk("R11", "busy_o", {31'b0, busy}, 32'd0);
    chk("R11", "done_o", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    rd(4'd0, d);
    chk("R11", "cfg after reset", d, 32'h0001_0008);

    // R1 illegal lengths rejected
    wr(4'd0, 32'h0003_0211); rd(4'd0, d); chk("R1", "len 17 rejected", d, 32'h0001_0008);
    wr(4'd0, 32'h0000_0C07); rd(4'd0, d); chk("R1", "len 7 rejected", d, 32'h0001_0008);
    wr(4'd0, 32'h0005_0021 | 32'h0000_0040); rd(4'd0, d); chk("R1", "len 33 rejected", d, 32'h0001_0008);
    rd(4'd2, d); chk("R1", "unmapped reads 0", d, 32'd0);

    xfer(32'h0001_0008, 32'hA5A5_3C3C);  // 8 bit, mode 0, MSB
    xfer(32'h0000_03D0, 32'h1357_9BDF);  // R2 16 bit x4, LSB, CPOL1
    xfer(32'h0001_0F60, 32'hF00D_BEEF);  // R7 32 bit x2, three-wire, mode 3
    xfer(32'h0000_00C9, 32'h0BAD_CAFE);  // 9 bit x4
    xfer(32'h0001_0518, 32'h7654_3210);  // 24 bit, LSB, CPHA1

    // R5 / R10: double buffering and stalled start
    load(32'h0002_0494, 32'h2468_ACE0); // 20 bit x3, CPHA1, N=2
    wr(4'd1, 32'd1);
    for (int i = 0; i < 4; i++) wr(4'd4 + 4'(i), 32'h5A5A_0000 + 32'(i));
    check_rx("R5");
    @(negedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'd1; bus_wdata = 32'd1;
    #1 chk("R10", "ready during busy", {31'b0, bus_ready}, 32'd0);
    while (!bus_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
    chk("R10", "second transfer started", {31'b0, busy}, 32'd1);
    wait_idle();
    check_rx("R4");
    rd(4'd1, d); chk("R9", "busy reads 0", d, 32'd0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule